// File: doc/BRIEF.md
# Keyboard Matrix Scanner with Precharge

This block reads a 12 by 7 key matrix on its own and reports each key that changes. At each column step it first precharges the row lines while every column is off. It then drives one column, waits for the rows to settle and captures the seven row bits into a snapshot of the whole matrix. One final precharge follows the last column. The scan rate comes from a millisecond tick and the settle times from a microsecond tick, so the block needs no knowledge of the system clock frequency.

When a scan is complete, a delta pass compares the snapshot with the last state reported for each key. Keys are visited in ascending index order. Each key that differs produces one event with its index and its new state, and the reported state is updated only when the consumer accepts the event. A consumer that holds off ready therefore stalls the pass without losing a change. An enable input stops all scanning and clears the pending scan period.

Top module: `kbd_matrix_scan`

## Requirements
- R1: After reset every column line and the charge strobe are low, no event is offered, and every key counts as released, so a first scan of an idle matrix yields no events.
- R2: The charge strobe is high for exactly SETTLE_US microsecond ticks before each column is driven. No column line is high while the strobe is high.
- R3: Columns are driven one at a time in ascending order 0 to 11. Column c is bit c of `col_sel`: bits 0 to 7 are the low group and bits 8 to 11 the upper group. Each column is held for SETTLE_US ticks and the rows are captured at the end of that window.
- R4: After column 11 all columns are released and one more charge pulse follows, which gives 13 charge pulses per scan.
- R5: Bit r of `row_in` taken while column c is driven is the state of key index r + 7*c, where 1 means pressed.
- R6: After each scan there is exactly one event for every key whose captured state differs from its last reported state. Events come in ascending index order, and `evt_pressed` carries the new state. Unchanged keys produce no event.
- R7: While `evt_valid` is high and `evt_ready` is low, the event stays offered with its index and flag unchanged, and no change is dropped.
- R8: A scan starts once PERIOD_MS millisecond ticks have been counted while enabled since the previous scan started (at least one tick). Fewer ticks start nothing.
- R9: While `enable` is low no scan runs, the columns and the strobe stay low, no new pass starts and the period count is cleared.
- R10: `press_seen` pulses for one cycle at the end of a delta pass in which at least one accepted event was a press. It stays low after a pass that emitted only releases or nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows scanning when high |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| row_in | input | 7 | Row levels from the matrix, 1 = pressed |
| col_sel | output | 12 | One-hot column drive; bits 0-7 low group, 8-11 upper group |
| charge | output | 1 | Row precharge strobe |
| evt_valid | output | 1 | Key change event offered |
| evt_ready | input | 1 | Consumer accepts the event |
| evt_index | output | 7 | Key index, row + 7*column |
| evt_pressed | output | 1 | New key state, 1 = pressed |
| press_seen | output | 1 | End-of-pass pulse if a press was reported |

## Verification
The hardest case to reach is a delta pass that is stalled in the middle of a burst of changes spread over many columns, including both corner keys 0 and 83. The pass must keep its place and must not update a reported state early. To get there, the stimulus loads a dense key pattern of mixed presses and releases while the consumer's ready toggles at random. A scoreboard checks each accepted event against the expected ascending list. Disabling the block with keys changed and ticks still arriving shows that nothing is scanned. After it is enabled again, the first scan reports exactly the changes it missed.

// File: rtl/kms_pkg.sv
// Package: shared state type for the key matrix scanner.
package kms_pkg;
    // Phases of the column sequencer.
    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_CHARGE = 2'd1,
        SQ_SELECT = 2'd2,
        SQ_TAIL   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/kms_period.sv
// kms_period: counts millisecond ticks while enabled and raises `due`
// once the scan period has elapsed. Assumes ms_tick is a one-cycle pulse.
// A period below one tick is raised to one.
module kms_period #(
    parameter int PERIOD_MS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ms_tick,
    input  logic clear,
    output logic due
);
    localparam int EFF = (PERIOD_MS < 1) ? 1 : PERIOD_MS;
    localparam int PW  = $clog2(EFF + 1);

    logic [PW-1:0] cnt;

    // Saturating tick counter; cleared by disable or by a scan start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!enable || clear) begin
            cnt <= '0;
        end else if (ms_tick && (cnt != PW'(EFF))) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign due = (cnt == PW'(EFF));
endmodule

// File: rtl/kms_column_seq.sv
// kms_column_seq: walks the columns. For each column it precharges with
// all columns off, drives the column, waits, then captures the row bits
// into the snapshot. One more precharge follows the last column, after
// which scan_done pulses. Assumes us_tick is a one-cycle pulse and that
// row_in settles within the select window. Disable aborts at once.
module kms_column_seq
    import kms_pkg::*;
#(
    parameter int NUM_COLS  = 12,
    parameter int NUM_ROWS  = 7,
    parameter int SETTLE_US = 20
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         enable,
    input  logic                         us_tick,
    input  logic                         start,
    input  logic [NUM_ROWS-1:0]          row_in,
    output logic [NUM_COLS-1:0]          col_sel,
    output logic                         charge,
    output logic [NUM_COLS*NUM_ROWS-1:0] snap,
    output logic                         scan_done,
    output logic                         busy
);
    localparam int SET_EFF = (SETTLE_US < 1) ? 1 : SETTLE_US;
    localparam int SW      = $clog2(SET_EFF + 1);
    localparam int CSW     = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1;

    seq_state_t     state;
    logic [CSW-1:0] col;
    logic [SW-1:0]  cnt;
    logic           win_end;

    // End of a settle window: last microsecond of the phase.
    assign win_end = us_tick && (cnt == SW'(SET_EFF - 1));

    // Phase sequencing, column stepping and row capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            col       <= '0;
            cnt       <= '0;
            snap      <= '0;
            scan_done <= 1'b0;
        end else begin
            scan_done <= 1'b0;
            if (!enable) begin
                state <= SQ_IDLE;
                col   <= '0;
                cnt   <= '0;
            end else begin
                case (state)
                    SQ_IDLE: begin
                        if (start) begin
                            state <= SQ_CHARGE;
                            col   <= '0;
                            cnt   <= '0;
                        end
                    end
                    SQ_CHARGE: begin
                        if (win_end) begin
                            cnt   <= '0;
                            state <= SQ_SELECT;
                        end else if (us_tick) begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    SQ_SELECT: begin
                        if (win_end) begin
                            cnt <= '0;
                            for (int c = 0; c < NUM_COLS; c++) begin
                                if (col == CSW'(c))
                                    snap[c*NUM_ROWS +: NUM_ROWS] <= row_in;
                            end
                            if (col == CSW'(NUM_COLS - 1)) begin
                                state <= SQ_TAIL;
                            end else begin
                                col   <= col + 1'b1;
                                state <= SQ_CHARGE;
                            end
                        end else if (us_tick) begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    SQ_TAIL: begin
                        if (win_end) begin
                            cnt       <= '0;
                            state     <= SQ_IDLE;
                            scan_done <= 1'b1;
                        end else if (us_tick) begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= SQ_IDLE;
                endcase
            end
        end
    end

    // One-hot column decode, only during the select window.
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        assign col_sel[c] = (state == SQ_SELECT) && (col == CSW'(c));
    end

    assign charge = (state == SQ_CHARGE) || (state == SQ_TAIL);
    assign busy   = (state != SQ_IDLE);
endmodule

// File: rtl/kms_delta.sv
// kms_delta: after a scan, visits every key in ascending index order and
// offers an event for each key whose snapshot bit differs from the last
// reported state. The reported state is updated on acceptance only.
// Assumes snap stays stable while busy.
module kms_delta #(
    parameter int KEYS = 84,
    parameter int IW   = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [KEYS-1:0] snap,
    input  logic            evt_ready,
    output logic            evt_valid,
    output logic [IW-1:0]   evt_index,
    output logic            evt_pressed,
    output logic            press_seen,
    output logic            busy
);
    logic [KEYS-1:0] prev;
    logic [IW-1:0]   idx;
    logic            active;
    logic            any_press;
    logic            cur_bit;
    logic            advance;

    assign cur_bit   = snap[idx];
    assign evt_valid = active && (cur_bit != prev[idx]);
    assign advance   = active && (!evt_valid || evt_ready);

    // Pass control, reported-state update and press summary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev       <= '0;
            idx        <= '0;
            active     <= 1'b0;
            any_press  <= 1'b0;
            press_seen <= 1'b0;
        end else begin
            press_seen <= 1'b0;
            if (!active) begin
                if (go) begin
                    active    <= 1'b1;
                    idx       <= '0;
                    any_press <= 1'b0;
                end
            end else if (advance) begin
                if (evt_valid) begin
                    prev[idx] <= cur_bit;
                    if (cur_bit) any_press <= 1'b1;
                end
                if (idx == IW'(KEYS - 1)) begin
                    active     <= 1'b0;
                    press_seen <= any_press || (evt_valid && cur_bit);
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    assign evt_index   = idx;
    assign evt_pressed = cur_bit;
    assign busy        = active;
endmodule

// File: rtl/kbd_matrix_scan.sv
// kbd_matrix_scan: top of the key matrix scanner. Joins the period
// counter, the column sequencer and the delta pass. A new scan starts only
// when both the sequencer and the delta pass are idle, so the snapshot is
// stable for the whole pass.
module kbd_matrix_scan #(
    parameter int NUM_COLS  = 12,
    parameter int NUM_ROWS  = 7,
    parameter int SETTLE_US = 20,
    parameter int PERIOD_MS = 50,
    localparam int KEYS     = NUM_COLS * NUM_ROWS,
    localparam int IW       = $clog2(KEYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                us_tick,
    input  logic                ms_tick,
    input  logic [NUM_ROWS-1:0] row_in,
    output logic [NUM_COLS-1:0] col_sel,
    output logic                charge,
    output logic                evt_valid,
    input  logic                evt_ready,
    output logic [IW-1:0]       evt_index,
    output logic                evt_pressed,
    output logic                press_seen
);
    logic            due;
    logic            start;
    logic            seq_busy;
    logic            delta_busy;
    logic            scan_done;
    logic [KEYS-1:0] snap;

    assign start = enable && due && !seq_busy && !delta_busy;

    kms_period #(.PERIOD_MS(PERIOD_MS)) u_period (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ms_tick(ms_tick),
        .clear(start), .due(due)
    );

    kms_column_seq #(
        .NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS), .SETTLE_US(SETTLE_US)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .us_tick(us_tick),
        .start(start), .row_in(row_in), .col_sel(col_sel), .charge(charge),
        .snap(snap), .scan_done(scan_done), .busy(seq_busy)
    );

    kms_delta #(.KEYS(KEYS), .IW(IW)) u_delta (
        .clk(clk), .rst_n(rst_n), .go(scan_done), .snap(snap),
        .evt_ready(evt_ready), .evt_valid(evt_valid), .evt_index(evt_index),
        .evt_pressed(evt_pressed), .press_seen(press_seen), .busy(delta_busy)
    );
endmodule

// File: rtl/kms_checker.sv
// kms_checker: port-level properties of the key matrix scanner, bound to
// every instance of the top module.
module kms_checker #(
    parameter int NUM_COLS = 12,
    parameter int IW       = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic                enable,
    input logic [NUM_COLS-1:0] col_sel,
    input logic                charge,
    input logic                evt_valid,
    input logic                evt_ready,
    input logic [IW-1:0]       evt_index,
    input logic                evt_pressed,
    input logic                press_seen
);
    a_r2_charge_cols_off: assert property (@(posedge clk) disable iff (!rst_n)
        charge |-> (col_sel == '0));

    a_r3_col_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_sel));

    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_index) && $stable(evt_pressed)));

    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ((col_sel == '0) && !charge));

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        press_seen |=> !press_seen);
endmodule

bind kbd_matrix_scan kms_checker #(.NUM_COLS(NUM_COLS), .IW(IW)) u_kms_checker (
    .clk(clk), .rst_n(rst_n), .enable(enable), .col_sel(col_sel),
    .charge(charge), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_index(evt_index), .evt_pressed(evt_pressed), .press_seen(press_seen)
);

// File: tb/test_kbd_matrix_scan.sv
`timescale 1ns/1ps
module test_kbd_matrix_scan;
    localparam int NC = 12;
    localparam int NR = 7;
    localparam int NK = NC * NR;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          us_tick = 1'b1;
    logic          ms_tick = 1'b0;
    logic [NR-1:0] row_in;
    logic [NC-1:0] col_sel;
    logic          charge;
    logic          evt_valid;
    logic          evt_ready = 1'b1;
    logic [6:0]    evt_index;
    logic          evt_pressed;
    logic          press_seen;

    int checks = 0;
    int errors = 0;

    typedef struct packed { logic [6:0] idx; logic pr; } ev_t;
    ev_t exp_q[$];

    logic [NK-1:0] keys = '0;
    logic [NK-1:0] model_prev = '0;
    bit            exp_press = 0;
    bit            ready_random = 0;
    int            charge_rises = 0;
    int            press_count = 0;
    int            exp_col = 0;
    int            run_len = 0;
    logic [NC-1:0] last_cols = '0;
    logic          last_charge = 1'b0;

    always #2.5 clk = ~clk;

    kbd_matrix_scan i_kbd_matrix_scan (
        .clk(clk), .rst_n(rst_n), .enable(enable), .us_tick(us_tick),
        .ms_tick(ms_tick), .row_in(row_in), .col_sel(col_sel), .charge(charge),
        .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_index(evt_index),
        .evt_pressed(evt_pressed), .press_seen(press_seen)
    );

    // Matrix model: rows of the driven column.
    always_comb begin
        row_in = '0;
        for (int c = 0; c < NC; c++)
            if (col_sel[c]) row_in = row_in | keys[c*NR +: NR];
    end

    // Ready driver, updated just after the rising edge.
    always @(posedge clk) begin
        #1;
        evt_ready <= ready_random ? 1'($urandom % 2) : 1'b1;
    end

    task automatic check(input bit ok, input string msg, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
        end
    endtask

    // Monitor: scoreboard pop, column order, charge pulse widths.
    always @(negedge clk) begin
        if (rst_n) begin
            if (evt_valid && evt_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R6 unexpected event index", int'(evt_index), -1);
                end else begin
                    ev_t e;
                    e = exp_q.pop_front();
                    check(evt_index == e.idx, "R5/R6 event index", int'(evt_index), int'(e.idx));
                    check(evt_pressed == e.pr, "R6 event pressed flag", int'(evt_pressed), int'(e.pr));
                end
            end
            if (press_seen) press_count++;
            if (charge && col_sel != '0)
                check(0, "R2 column driven during charge", int'(col_sel), 0);
            if (col_sel != '0 && col_sel != last_cols) begin
                check(col_sel == NC'(1 << exp_col), "R3 column order", int'(col_sel), 1 << exp_col);
                exp_col++;
            end
            if (charge && !last_charge) charge_rises++;
            if (charge) run_len++;
            else if (run_len != 0) begin
                check(run_len == 20, "R2 charge pulse width", run_len, 20);
                run_len = 0;
            end
            last_cols   = col_sel;
            last_charge = charge;
        end
    end

    // Driver: set the matrix and push the expected ascending event list.
    task automatic apply_keys(input logic [NK-1:0] nk);
        exp_press = 0;
        for (int i = 0; i < NK; i++) begin
            if (nk[i] != model_prev[i]) begin
                exp_q.push_back('{idx: 7'(i), pr: nk[i]});
                if (nk[i]) exp_press = 1;
            end
        end
        model_prev = nk;
        keys = nk;
    endtask

    task automatic pulse_ms(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ms_tick = 1'b1;
        end
        @(negedge clk) ms_tick = 1'b0;
    endtask

    // One full scan with end-of-scan checks.
    task automatic run_scan(input string tag);
        int r0, p0;
        r0 = charge_rises;
        p0 = press_count;
        exp_col = 0;
        pulse_ms(50);
        repeat (2500) @(negedge clk);
        check(exp_q.size() == 0, {tag, " R6 events outstanding"}, exp_q.size(), 0);
        check(charge_rises - r0 == 13, {tag, " R4 charge pulses per scan"}, charge_rises - r0, 13);
        check(exp_col == 12, {tag, " R3 columns visited"}, exp_col, 12);
        check(press_count - p0 == int'(exp_press), {tag, " R10 press summary"},
              press_count - p0, int'(exp_press));
    endtask

    bit done = 0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NK-1:0] pat;
        int r0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(col_sel == '0, "R1 columns after reset", int'(col_sel), 0);
        check(charge == 1'b0, "R1 charge after reset", int'(charge), 0);
        check(evt_valid == 1'b0, "R1 no event after reset", int'(evt_valid), 0);
        check(press_seen == 1'b0, "R1 no summary after reset", int'(press_seen), 0);
        enable = 1'b1;

        // R1: idle matrix after reset gives no events
        apply_keys('0);
        run_scan("idle");

        // R5: corner keys 0 and 83 plus key 40 (row 5, column 5)
        pat = '0; pat[0] = 1'b1; pat[83] = 1'b1; pat[40] = 1'b1;
        apply_keys(pat);
        run_scan("corners");

        // R6: mixed release and presses in adjacent columns
        pat[0] = 1'b0; pat[6] = 1'b1; pat[7] = 1'b1;
        apply_keys(pat);
        run_scan("mixed");

        // R10: releases only
        apply_keys('0);
        run_scan("release");

        // R7: dense pattern under random backpressure
        ready_random = 1;
        pat = {20'hA5C3F, 32'h0F0F_3C3C, 32'h9999_6666};
        apply_keys(pat);
        run_scan("stall");
        pat = ~pat;
        apply_keys(pat);
        run_scan("stall2");
        ready_random = 0;

        // R8: 49 ticks start nothing; the 50th starts a scan
        r0 = charge_rises;
        exp_press = 0;
        pulse_ms(49);
        repeat (800) @(negedge clk);
        check(charge_rises == r0, "R8 early scan", charge_rises - r0, 0);
        exp_col = 0;
        pulse_ms(1);
        repeat (2500) @(negedge clk);
        check(charge_rises - r0 == 13, "R8 scan after full period", charge_rises - r0, 13);

        // R9: disabled, keys changed, ticks arrive: nothing happens
        enable = 1'b0;
        keys = '0;
        keys[83] = 1'b1;
        r0 = charge_rises;
        pulse_ms(60);
        repeat (800) @(negedge clk);
        check(charge_rises == r0, "R9 scan while disabled", charge_rises - r0, 0);
        check(col_sel == '0, "R9 columns while disabled", int'(col_sel), 0);
        enable = 1'b1;
        pat = '0; pat[83] = 1'b1;
        apply_keys(pat);
        run_scan("reenable");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule